// File: doc/BRIEF.md
# Multiplexed Bus Exchanger

This block joins a narrow data port to a wide one made of two equal halves. On the way from narrow to wide, one edge-triggered register stands behind each wide half. Each register loads the narrow input word on a rising clock edge, but only while its own active-low capture enable is low. Driving the two enables one after the other packs two successive narrow words side by side into one wide word. The wide output always shows what the registers hold.

On the way from wide to narrow, one transparent latch stands behind each wide half. A latch follows its half of the wide input while its active-low latch enable is low, and it keeps its value while that enable is high. This path needs no clock. A half-select input picks which latch drives the narrow output.

Each output has an active-low output enable. Three-state pins are modelled as a data output plus a separate drive flag. A synchronous active-high reset clears the capture registers. It does not touch the latches, whose contents are unknown until they are first opened.

Top module: `bus_exchanger`

## Requirements
- R1: On a rising clock edge with reset low, when `cap_en_n[0]` is low, the first half `b_out[11:0]` takes the value of `a_in`.
- R2: `cap_en_n[1]` controls the second half `b_out[23:12]` in the same way. The two enables act independently of each other, so alternating them places two successive `a_in` words in the two halves.
- R3: A half whose capture enable is high at a rising edge keeps its previous value.
- R4: When `rst` is high at a rising edge, both halves of `b_out` become zero, whatever the capture enables are.
- R5: While `latch_en_n[h]` is low, latch h follows input half h (h=0 is `b_in[11:0]`, h=1 is `b_in[23:12]`), with no clock needed.
- R6: While `latch_en_n[h]` is high, latch h keeps the last value it passed, even when `b_in` changes.
- R7: `half_sel`=0 puts latch 0 on `a_out`, and `half_sel`=1 puts latch 1 on `a_out`.
- R8: `a_drive` is 1 exactly when `a_oe_n` is 0, and `b_drive` is 1 exactly when `b_oe_n` is 0. The output enables do not change the data on `a_out` or `b_out`.
- R9: Reset and clock edges do not change the contents of a closed latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rst | input | 1 | Synchronous active-high reset of the capture registers |
| a_in | input | 12 | Narrow input word |
| cap_en_n | input | 2 | Active-low capture enables, bit h for wide half h |
| b_out | output | 24 | Wide output built from the two capture registers |
| b_oe_n | input | 1 | Active-low output enable of the wide side |
| b_drive | output | 1 | Drive flag of the wide side |
| b_in | input | 24 | Wide input word |
| latch_en_n | input | 2 | Active-low latch enables, bit h for wide half h |
| half_sel | input | 1 | Picks latch 0 or latch 1 for the narrow output |
| a_out | output | 12 | Narrow output word |
| a_oe_n | input | 1 | Active-low output enable of the narrow side |
| a_drive | output | 1 | Drive flag of the narrow side |

## Verification
The bench steps through every combination of the two capture enables and the two latch enables, both select values and both output enable values, with changing data. A design that swapped the halves, or tied one enable to both registers, would put a word in the wrong half or overwrite the half that should hold. The bench closes a latch and then changes the wide input, pulses reset and toggles the clock. A latch that stayed open, or that was cleared by reset, would then show the new or zeroed data on the narrow output. Reset is asserted while both capture enables are low, which exposes a design that lets a capture win over the clear.

// File: rtl/bx_pkg.sv
package bx_pkg;

    localparam int unsigned BX_NARROW_W = 12;
    localparam int unsigned BX_HALVES   = 2;

    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_pick_e;

    function automatic int unsigned sel_width(input int unsigned halves);
        return (halves > 1) ? $clog2(halves) : 1;
    endfunction

endpackage

// File: rtl/bx_capture_reg.sv
module bx_capture_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!cap_en_n) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bx_hold_latch.sv
module bx_hold_latch #(
    parameter int unsigned W = 12
) (
    input  logic         le_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_latch begin
        if (!le_n) begin
            q = d;
        end
    end
endmodule

// File: rtl/bx_half_mux.sv
module bx_half_mux #(
    parameter int unsigned W      = 12,
    parameter int unsigned HALVES = 2,
    parameter int unsigned SEL_W  = 1
) (
    input  logic [HALVES-1:0][W-1:0] halves,
    input  logic [SEL_W-1:0]         sel,
    output logic [W-1:0]             y
);
    always_comb begin
        y = '0;
        for (int unsigned h = 0; h < HALVES; h++) begin
            if (sel == SEL_W'(h)) begin
                y = halves[h];
            end
        end
    end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned W      = BX_NARROW_W,
    parameter int unsigned HALVES = BX_HALVES,
    localparam int unsigned WIDE_W = W * HALVES,
    localparam int unsigned SEL_W  = sel_width(HALVES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      a_in,
    input  logic [HALVES-1:0] cap_en_n,
    output logic [WIDE_W-1:0] b_out,
    input  logic              b_oe_n,
    output logic              b_drive,
    input  logic [WIDE_W-1:0] b_in,
    input  logic [HALVES-1:0] latch_en_n,
    input  logic [SEL_W-1:0]  half_sel,
    output logic [W-1:0]      a_out,
    input  logic              a_oe_n,
    output logic              a_drive
);
    logic [HALVES-1:0][W-1:0] cap_q;
    logic [HALVES-1:0][W-1:0] lat_q;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        bx_capture_reg #(.W(W)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .cap_en_n (cap_en_n[h]),
            .d        (a_in),
            .q        (cap_q[h])
        );

        bx_hold_latch #(.W(W)) u_lat (
            .le_n (latch_en_n[h]),
            .d    (b_in[h*W +: W]),
            .q    (lat_q[h])
        );
    end

    bx_half_mux #(.W(W), .HALVES(HALVES), .SEL_W(SEL_W)) u_mux (
        .halves (lat_q),
        .sel    (half_sel),
        .y      (a_out)
    );

    assign b_out   = cap_q;
    assign b_drive = ~b_oe_n;
    assign a_drive = ~a_oe_n;
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
    parameter int unsigned W      = 12,
    parameter int unsigned HALVES = 2,
    localparam int unsigned WIDE_W = W * HALVES,
    localparam int unsigned SEL_W  = bx_pkg::sel_width(HALVES)
) (
    input logic              clk,
    input logic              rst,
    input logic [W-1:0]      a_in,
    input logic [HALVES-1:0] cap_en_n,
    input logic [WIDE_W-1:0] b_out,
    input logic              b_oe_n,
    input logic              b_drive,
    input logic [WIDE_W-1:0] b_in,
    input logic [HALVES-1:0] latch_en_n,
    input logic [SEL_W-1:0]  half_sel,
    input logic [W-1:0]      a_out,
    input logic              a_oe_n,
    input logic              a_drive
);
    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        AST_HALF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            !cap_en_n[h] |=> b_out[h*W +: W] == $past(a_in)); // R1
        AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
            cap_en_n[h] |=> $stable(b_out[h*W +: W])); // R3
        AST_LATCH_PASS: assert property (@(posedge clk) disable iff (rst)
            (!latch_en_n[h] && half_sel == SEL_W'(h)) |-> a_out == b_in[h*W +: W]); // R5
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> b_out == '0); // R4
    AST_A_DRIVE: assert property (@(posedge clk)
        a_drive != a_oe_n); // R8
    AST_B_DRIVE: assert property (@(posedge clk)
        b_drive != b_oe_n); // R8
endmodule

bind bus_exchanger bx_checker #(.W(W), .HALVES(HALVES)) u_chk (.*);

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;
    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] a_in;
    logic [1:0]  cap_en_n;
    logic [23:0] b_out;
    logic        b_oe_n;
    logic        b_drive;
    logic [23:0] b_in;
    logic [1:0]  latch_en_n;
    logic [0:0]  half_sel;
    logic [11:0] a_out;
    logic        a_oe_n;
    logic        a_drive;

    int errors = 0;
    int checks = 0;

    logic [11:0] m_reg0, m_reg1, m_lat0, m_lat1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_exchanger uut (
        .clk(clk), .rst(rst), .a_in(a_in), .cap_en_n(cap_en_n),
        .b_out(b_out), .b_oe_n(b_oe_n), .b_drive(b_drive), .b_in(b_in),
        .latch_en_n(latch_en_n), .half_sel(half_sel), .a_out(a_out),
        .a_oe_n(a_oe_n), .a_drive(a_drive)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the latch path: an open latch follows its half.
    task automatic model_latches();
        if (!latch_en_n[0]) m_lat0 = b_in[11:0];
        if (!latch_en_n[1]) m_lat1 = b_in[23:12];
    endtask

    // One clock: inputs are already set at the negedge; wait to the next negedge.
    task automatic step();
        @(negedge clk);
        if (rst) begin
            m_reg0 = '0;
            m_reg1 = '0;
        end else begin
            if (!cap_en_n[0]) m_reg0 = a_in;
            if (!cap_en_n[1]) m_reg1 = a_in;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; a_in = '0; cap_en_n = 2'b11; b_oe_n = 1'b1; a_oe_n = 1'b1;
        b_in = '0; latch_en_n = 2'b11; half_sel = 1'b0;
        m_reg0 = '0; m_reg1 = '0; m_lat0 = '0; m_lat1 = '0;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        check("R4 reset state b_out", b_out, 24'h0);
        check("R8 reset a_drive off", {23'b0, a_drive}, 24'h0);
        check("R8 reset b_drive off", {23'b0, b_drive}, 24'h0);

        // Open both latches once so their contents are known.
        b_in = 24'h5A5_3C3; latch_en_n = 2'b00; #1; model_latches();
        latch_en_n = 2'b11;

        // R2: alternating enables pack two sequential words.
        a_in = 12'hABC; cap_en_n = 2'b10; step();
        a_in = 12'h123; cap_en_n = 2'b01; step();
        cap_en_n = 2'b11;
        check("R2 packed wide word", b_out, 24'h123_ABC);
        check("R1 first half", {12'h0, b_out[11:0]}, {12'h0, 12'hABC});

        // R3: both enables high, input changes, no change on output.
        a_in = 12'hFFF; step(); step();
        check("R3 hold with enables high", b_out, 24'h123_ABC);

        // Sweep over all enable/select/output-enable patterns.
        for (int i = 0; i < 256; i++) begin
            a_in       = 12'((i * 293 + 17) & 12'hFFF);
            b_in       = 24'((i * 40503 + 911) & 24'hFFFFFF);
            cap_en_n   = 2'(i % 4);
            latch_en_n = 2'((i / 4) % 4);
            half_sel   = 1'((i / 16) % 2);
            a_oe_n     = 1'((i / 32) % 2);
            b_oe_n     = 1'((i / 64) % 2);
            #1;
            model_latches();
            check("R5 R6 R7 latch path on a_out", {12'h0, a_out},
                  {12'h0, half_sel ? m_lat1 : m_lat0});
            check("R8 a_drive", {23'b0, a_drive}, {23'b0, ~a_oe_n});
            check("R8 b_drive", {23'b0, b_drive}, {23'b0, ~b_oe_n});
            step();
            check("R1 R2 R3 capture halves", b_out, {m_reg1, m_reg0});
        end

        // R6: closed latch ignores a changing wide input.
        b_in = 24'h111_222; latch_en_n = 2'b00; #1; model_latches();
        latch_en_n = 2'b11;
        b_in = 24'hEEE_DDD; half_sel = 1'b0; #1;
        check("R6 closed latch 0 holds", {12'h0, a_out}, {12'h0, 12'h222});
        half_sel = 1'b1; #1;
        check("R7 select latch 1", {12'h0, a_out}, {12'h0, 12'h111});

        // R5: reopen only latch 1, latch 0 stays.
        latch_en_n = 2'b01; #1;
        check("R5 latch 1 transparent", {12'h0, a_out}, {12'h0, 12'hEEE});
        b_in = 24'h777_888; #1;
        check("R5 latch 1 follows", {12'h0, a_out}, {12'h0, 12'h777});
        half_sel = 1'b0; #1;
        check("R6 latch 0 still held", {12'h0, a_out}, {12'h0, 12'h222});
        latch_en_n = 2'b11;

        // R4 and R9: reset with capture enabled clears registers, leaves latches.
        a_in = 12'h9A9; cap_en_n = 2'b00; rst = 1'b1; step(); step();
        rst = 1'b0; cap_en_n = 2'b11;
        check("R4 reset wins over capture", b_out, 24'h0);
        half_sel = 1'b0; #1;
        check("R9 latch 0 kept across reset", {12'h0, a_out}, {12'h0, 12'h222});
        half_sel = 1'b1; #1;
        check("R9 latch 1 kept across reset", {12'h0, a_out}, {12'h0, 12'h777});

        // R8: output enables leave data unchanged.
        a_in = 12'h4D2; cap_en_n = 2'b00; b_oe_n = 1'b1; a_oe_n = 1'b1; step();
        cap_en_n = 2'b11;
        check("R8 data with b_oe_n high", b_out, 24'h4D2_4D2);
        check("R8 data with a_oe_n high", {12'h0, a_out}, {12'h0, 12'h777});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule